// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock, data line) and turns each frame into a pair of 24-bit signed samples. It runs directly on the bit clock. A 2-bit format input, which may change at run time, picks one of four framings: I2S, left-justified with a word of up to 24 bits, and right-justified with a word of exactly 24 or 16 bits.

The left and right samples are presented together, with a one-cycle valid strobe, once the right channel of a frame has ended. A frame-length check raises an error flag alongside the samples when a frame has too few bit clocks for the selected format. A change of format drops the frame in progress. Capture restarts cleanly at the next frame-clock transition.

Top module: `serial_audio_rx`

## Requirements
- R1: Format 2'b10 (left-justified): the bit sampled on the first bit-clock rising edge after a frame-clock change is the MSB. Bits follow MSB first. Bits beyond the word length arrive as zeros, so a word shorter than 24 bits comes out left-aligned in the 24-bit sample with zero low bits. A high frame clock marks the left channel.
- R2: Format 2'b00 (I2S): the MSB is the bit sampled one bit-clock cycle after the first cycle of the half-frame, with the same left alignment and zero fill as R1. A low frame clock marks the left channel.
- R3: Format 2'b01 (right-justified, 24 bits): the sample is the last 24 bits received before the frame-clock change. The LSB is the bit sampled in the final cycle of the half-frame. A high frame clock marks the left channel.
- R4: Format 2'b11 (right-justified, 16 bits): the sample is the last 16 bits received before the frame-clock change, sign-extended to 24 bits. A high frame clock marks the left channel.
- R5: Both sample outputs update together on the edge where the right channel ends, with valid_o high for exactly that one cycle. At all other times the outputs hold their values.
- R6: frame_err_o is updated with each valid frame. It is 1 when the frame held fewer than 32 bit clocks in format 2'b10, or fewer than 48 in format 2'b11. It is always 0 in the other formats.
- R7: The per-half bit counter saturates at 63 and does not wrap. Half-frames longer than 63 bit clocks still capture correctly and count as long enough.
- R8: A change on mode_i discards the frame in progress: no valid pulse is produced for it. Capture resumes with the frame that starts at the next frame-clock change.
- R9: After reset both samples are zero and valid_o is low. The first valid pulse follows the first left-then-right frame whose left half began with a frame-clock change seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock; data sampled on rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Framing format: 00 I2S, 01 RJ24, 10 LJ, 11 RJ16 |
| lrclk_i | input | 1 | Frame clock selecting the channel |
| sdata_i | input | 1 | Serial data line |
| left_o | output | 24 | Left sample, signed, 24 bits |
| right_o | output | 24 | Right sample, signed, 24 bits |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| frame_err_o | output | 1 | Last frame had too few bit clocks for the format |

## Verification
The assertions watch every cycle for the following:
- the single-cycle shape of the valid strobe and the fact that it comes only on a frame-clock change;
- the outputs holding between strobes;
- sign extension in the 16-bit right-justified format;
- the error flag appearing only in the two formats that have a minimum;
- counter saturation;
- suppression of the strobe after a mode change.

Only the bench scenarios can show that the bit placement is right in each format. The same goes for short and over-long half-frames, the exact 32/48 clock thresholds, the dropping of a frame torn by a mode change, and the discarding of the partial first frame after reset.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ   = 2'b10,
    FMT_RJ16 = 2'b11
  } fmt_e;
endpackage

// File: rtl/sarx_bit_cnt.sv
module sarx_bit_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= CNT_W'(1);
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)) else $error("cnt wrapped"); // R7
endmodule

// File: rtl/sarx_left_cap.sv
module sarx_left_cap #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,   // first cycle of a half-frame
  input  logic              delay_i,   // MSB one cycle late
  input  logic [CNT_W-1:0]  idx_i,     // bit slot in half-frame
  input  logic              sdata_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [CNT_W:0]    pos;

  // wraps to a large value for the skipped slot, so no bit is written
  assign pos = {1'b0, idx_i} - {{CNT_W{1'b0}}, delay_i};

  always_comb begin
    acc_d = start_i ? '0 : acc_q;
    for (int b = 0; b < DATA_W; b++) begin
      if (pos == (CNT_W+1)'(DATA_W-1-b)) acc_d[b] = sdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign word_o = acc_q;
endmodule

// File: rtl/sarx_right_shift.sv
module sarx_right_shift #(
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              short_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] short_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[DATA_W-2:0], sdata_i};
  end

  generate
    if (SHORT_W < DATA_W) begin : g_sext
      assign short_word = {{(DATA_W-SHORT_W){sh_q[SHORT_W-1]}}, sh_q[SHORT_W-1:0]};
    end else begin : g_full
      assign short_word = sh_q;
    end
  endgenerate

  assign word_o = short_i ? short_word : sh_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int SHORT_W  = 16,
  parameter int CNT_W    = 6,
  parameter int MIN_LJ   = 32,
  parameter int MIN_RJ16 = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o,
  output logic              frame_err_o
);
  localparam int TOT_W = CNT_W + 1;

  fmt_e mode;
  assign mode = fmt_e'(mode_i);

  logic lr_q, init_q, half_ok_q, left_ok_q;
  logic [1:0] mode_q;
  logic [CNT_W-1:0]  cnt, left_len_q;
  logic [DATA_W-1:0] left_hold_q, lj_word, rj_word, word;
  logic fr_edge, mode_chg, left_lvl, ended_left, is_rj, too_short;
  logic [TOT_W-1:0] total;

  assign fr_edge    = init_q && (lrclk_i != lr_q);
  assign mode_chg   = (mode_i != mode_q);
  assign left_lvl   = (mode != FMT_I2S);
  assign ended_left = (lr_q == left_lvl);
  assign is_rj      = (mode == FMT_RJ24) || (mode == FMT_RJ16);
  assign word       = is_rj ? rj_word : lj_word;

  sarx_bit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(fr_edge), .cnt_o(cnt)
  );

  sarx_left_cap #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lcap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(fr_edge),
    .delay_i(mode == FMT_I2S),
    .idx_i  (fr_edge ? '0 : cnt),
    .sdata_i(sdata_i),
    .word_o (lj_word)
  );

  sarx_right_shift #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_rsh (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdata_i(sdata_i),
    .short_i(mode == FMT_RJ16),
    .word_o (rj_word)
  );

  assign total = {1'b0, left_len_q} + {1'b0, cnt};
  always_comb begin
    too_short = 1'b0;
    if (mode == FMT_LJ)   too_short = (total < TOT_W'(MIN_LJ));
    if (mode == FMT_RJ16) too_short = (total < TOT_W'(MIN_RJ16));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q        <= 1'b0;
      init_q      <= 1'b0;
      mode_q      <= 2'b00;
      half_ok_q   <= 1'b0;
      left_ok_q   <= 1'b0;
      left_len_q  <= '0;
      left_hold_q <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      lr_q    <= lrclk_i;
      init_q  <= 1'b1;
      mode_q  <= mode_i;
      valid_o <= 1'b0;
      if (mode_chg) begin
        half_ok_q <= 1'b0;
        left_ok_q <= 1'b0;
      end else if (fr_edge) begin
        half_ok_q <= 1'b1;
        left_ok_q <= 1'b0;
        if (half_ok_q && ended_left) begin
          left_hold_q <= word;
          left_len_q  <= cnt;
          left_ok_q   <= 1'b1;
        end else if (half_ok_q && left_ok_q) begin
          left_o      <= left_hold_q;
          right_o     <= word;
          valid_o     <= 1'b1;
          frame_err_o <= too_short;
        end
      end
    end
  end

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o) else $error("valid wider than one cycle"); // R5
  AST_VALID_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fr_edge)) else $error("valid without frame edge"); // R5
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))) else $error("samples moved"); // R5
  AST_RJ16_SEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(mode_i) == 2'b11) |->
      (right_o[DATA_W-1:SHORT_W] == {(DATA_W-SHORT_W){right_o[SHORT_W-1]}}))
    else $error("rj16 not sign-extended"); // R4
  AST_ERR_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frame_err_o) |-> $past(mode_i[1])) else $error("error in unchecked mode"); // R6
  AST_MODE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != mode_q) |=> !valid_o) else $error("valid after mode change"); // R8
endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  m;
    logic [7:0]  h;
    logic [7:0]  l;
    logic [23:0] lw;
    logic [23:0] rw;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 8'd32, 8'd24, 24'hA5A5A5, 24'h5A5A5A},
    '{2'b10, 8'd16, 8'd16, 24'h008123, 24'h007FFE},
    '{2'b10, 8'd15, 8'd16, 24'h00F00F, 24'h000FF0},
    '{2'b10, 8'd70, 8'd24, 24'h800001, 24'hC00003},
    '{2'b00, 8'd32, 8'd24, 24'h812345, 24'h7EDCBA},
    '{2'b00, 8'd32, 8'd20, 24'h09ABCD, 24'h012345},
    '{2'b00, 8'd70, 8'd24, 24'hFFFFFF, 24'h800000},
    '{2'b00, 8'd20, 8'd16, 24'h008001, 24'h004002},
    '{2'b01, 8'd32, 8'd24, 24'h876543, 24'h123456},
    '{2'b01, 8'd24, 8'd24, 24'h00FF00, 24'hFF00FF},
    '{2'b11, 8'd32, 8'd16, 24'h008001, 24'h007FFF},
    '{2'b11, 8'd24, 8'd16, 24'h00FFFF, 24'h000001},
    '{2'b11, 8'd23, 8'd16, 24'h008000, 24'h001234},
    '{2'b11, 8'd70, 8'd16, 24'h00C3A5, 24'h005A3C}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b10;
  logic lr = 1'b1, sd = 1'b0;
  logic [23:0] left_o, right_o;
  logic valid_o, frame_err_o;

  int n_chk = 0, n_bad = 0, ev_n = 0;
  logic [23:0] ev_l = '0, ev_r = '0;
  logic ev_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .lrclk_i(lr), .sdata_i(sd),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .frame_err_o(frame_err_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      ev_n++;
      ev_l = left_o; ev_r = right_o; ev_err = frame_err_o;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic lvl_left(input logic [1:0] m);
    return (m != 2'b00);
  endfunction

  function automatic logic bit_at(input logic [1:0] m, input int h, input int l,
                                  input logic [23:0] w, input int idx);
    case (m)
      2'b10:   return (idx < l) ? w[l-1-idx] : 1'b0;
      2'b00:   return (idx >= 1 && idx - 1 < l) ? w[l-idx] : 1'b0;
      default: return (idx >= h - l) ? w[h-1-idx] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] exp_word(input logic [1:0] m, input int h,
                                           input int l, input logic [23:0] w);
    int off, n;
    logic [47:0] t;
    case (m)
      2'b01: return w;
      2'b11: return {{8{w[15]}}, w[15:0]};
      default: begin
        off = (m == 2'b00) ? 1 : 0;
        n = l;
        if (h - off < n) n = h - off;
        if (n > 24) n = 24;
        t = {24'b0, w} >> (l - n);
        t = t << (24 - n);
        return t[23:0];
      end
    endcase
  endfunction

  function automatic logic exp_err(input logic [1:0] m, input int h);
    int c;
    c = (h > 63) ? 126 : 2 * h;
    if (m == 2'b10) return c < 32;
    if (m == 2'b11) return c < 48;
    return 1'b0;
  endfunction

  task automatic drive(input logic lv, input logic b);
    @(negedge clk);
    lr = lv; sd = b;
  endtask

  task automatic send_half(input logic [1:0] m, input logic lv, input int h,
                           input int l, input logic [23:0] w);
    for (int i = 0; i < h; i++) drive(lv, bit_at(m, h, l, w, i));
  endtask

  task automatic send_frame(input logic [1:0] m, input int h, input int l,
                            input logic [23:0] lw, input logic [23:0] rw);
    send_half(m, lvl_left(m), h, l, lw);
    send_half(m, !lvl_left(m), h, l, rw);
  endtask

  task automatic trail(input logic [1:0] m);
    for (int i = 0; i < 8; i++) drive(lvl_left(m), 1'b0);
    for (int i = 0; i < 8; i++) drive(!lvl_left(m), 1'b0);
  endtask

  task automatic prep_mode(input logic [1:0] m);
    @(negedge clk);
    mode = m;
    if (lr == lvl_left(m)) drive(!lvl_left(m), 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n0;
    string tag;
    logic [23:0] el, er;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(left_o == 24'h0, "R9", "reset left", 32'(left_o), 32'h0);
    chk(right_o == 24'h0, "R9", "reset right", 32'(right_o), 32'h0);
    chk(valid_o == 1'b0, "R9", "reset valid", 32'(valid_o), 32'h0);
    rst_n = 1'b1;

    // partial first frame: left half starts without a seen transition
    send_half(2'b10, 1'b1, 20, 16, 24'h00FFFF);
    send_half(2'b10, 1'b0, 20, 16, 24'h00FFFF);
    send_half(2'b10, 1'b1, 32, 24, 24'h123456);
    chk(ev_n == 0, "R9", "no strobe for partial frame", 32'(ev_n), 32'h0);
    send_half(2'b10, 1'b0, 32, 24, 24'h654321);
    trail(2'b10);
    chk(ev_n == 1, "R9", "first full frame strobes once", 32'(ev_n), 32'h1);
    chk(ev_l == 24'h123456, "R9", "first left", 32'(ev_l), 32'h123456);
    chk(ev_r == 24'h654321, "R9", "first right", 32'(ev_r), 32'h654321);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      case (v.m)
        2'b10: tag = "R1";
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        default: tag = "R4";
      endcase
      if (v.h > 63) tag = {tag, "/R7"};
      el = exp_word(v.m, int'(v.h), int'(v.l), v.lw);
      er = exp_word(v.m, int'(v.h), int'(v.l), v.rw);
      prep_mode(v.m);
      send_frame(v.m, int'(v.h), int'(v.l), v.lw, v.rw);
      send_frame(v.m, int'(v.h), int'(v.l), v.lw, v.rw);
      n0 = ev_n;
      trail(v.m);
      chk(ev_n == n0 + 1, "R5", $sformatf("vec %0d single strobe", i), 32'(ev_n - n0), 32'h1);
      chk(ev_l == el, tag, $sformatf("vec %0d left", i), 32'(ev_l), 32'(el));
      chk(ev_r == er, tag, $sformatf("vec %0d right", i), 32'(ev_r), 32'(er));
      chk(ev_err == exp_err(v.m, int'(v.h)), "R6", $sformatf("vec %0d frame_err", i),
          32'(ev_err), 32'(exp_err(v.m, int'(v.h))));
      chk(left_o == el && right_o == er, "R5", $sformatf("vec %0d held", i),
          32'(left_o), 32'(el));
    end

    // R8: mode glitch in the middle of a right half drops that frame
    prep_mode(2'b10);
    send_frame(2'b10, 32, 24, 24'h111111, 24'h222222);
    send_half(2'b10, 1'b1, 32, 24, 24'hABCDEF);
    n0 = ev_n;
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1);
    @(negedge clk); mode = 2'b00;
    @(negedge clk); mode = 2'b10;
    for (int i = 0; i < 8; i++) drive(1'b0, 1'b1);
    send_frame(2'b10, 32, 24, 24'h0F0F0F, 24'h3C3C3C);
    chk(ev_n == n0, "R8", "torn frame dropped", 32'(ev_n - n0), 32'h0);
    trail(2'b10);
    chk(ev_n == n0 + 1, "R8", "capture resumes", 32'(ev_n - n0), 32'h1);
    chk(ev_l == 24'h0F0F0F, "R8", "resumed left", 32'(ev_l), 32'h0F0F0F);
    chk(ev_r == 24'h3C3C3C, "R8", "resumed right", 32'(ev_r), 32'h3C3C3C);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule